// File: doc/BRIEF.md
# Segment LCD Frame Timing Generator

This block turns a single LCD clock into the complete time base for a multiplexed segment display. The clock first passes a power-of-two prescaler, then a divider whose ratio is 16 plus a programmable offset. Each period of the divider output is one common (COM) phase. The phases step through the common lines of the selected duty to make up a frame.

After every second frame, a programmable number of idle dead-time phases can be inserted. The block also produces a start-of-frame tick, a short drive-pulse window at the start of each phase, and a blink state. The blink state toggles after a power-of-two number of frames and is turned into per-COM "forced off" masks for the selected blink scope.

All configuration arrives as static fields. Software changes them only while `enable` is low. The block drives no analog circuitry. Downstream waveform logic uses its outputs to select bias levels and gate the pixel data.

Top module: `lcd_frame_timer`

## Requirements
- R1: Every COM phase lasts 2^P × (16 + D) clock cycles, where P = `cfg_prescale` (0..15) selects the power-of-two prescaler.
- R2: The divider ratio is 16 + D, where D = `cfg_divide` (0..15), so a phase spans 16 to 31 prescaled periods.
- R3: `cfg_duty` codes 000, 001, 010, 011 and 100 give 1, 2, 3, 4 and 8 common lines. Outside dead time, `com_idx` counts 0,1,…,N−1 and then returns to 0, advancing once per phase.
- R4: `cfg_duty` codes 101, 110 and 111 behave exactly like code 000 (static, one common line).
- R5: `sof` is high for exactly one clock: the first clock of COM phase 0 of every frame that is not dead time.
- R6: `drive_en` is high during the first W prescaled periods (W × 2^P clocks) of every non-dead phase, where W = `cfg_pulse` (0..7). W = 0 means `drive_en` never rises.
- R7: With `cfg_hidrive` = 1 the pulse width is one prescaled period, whatever `cfg_pulse` holds.
- R8: After every second frame, `cfg_dead` (0..7) whole phases are inserted. During these phases `dead_phase` = 1, `com_idx` = 0, and both `drive_en` and `sof` are low. A value of 0 inserts none.
- R9: The blink state starts in the "on" half. It toggles each time 2^(3+B) frames have completed, where B = `cfg_blink_rate` (0..7). Dead phases are not counted as frames.
- R10: `cfg_blink_sel` decides which pixels are forced off during the "off" half. Code 00 forces none. Code 01 sets only bit 0 of `blink_seg0_off`. Code 10 sets, in `blink_seg0_off`, the bits of all active COM lines. Code 11 sets those bits in both `blink_seg0_off` and `blink_rest_off`. Bit i of a mask corresponds to COM line i. Both masks are zero during the "on" half.
- R11: While `enable` is low, every output is zero and every counter is cleared. The first enabled cycle restarts at phase 0 and raises `sof`.
- R12: While `rst_n` is low, the counters hold zero. With `enable` high this shows as `com_idx` = 0, `sof` = 1, `dead_phase` = 0 and both masks zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the timing chain; low clears it |
| cfg_prescale | input | 4 | Prescaler exponent P |
| cfg_divide | input | 4 | Divider offset D (ratio 16+D) |
| cfg_duty | input | 3 | Duty code |
| cfg_pulse | input | 3 | Drive-pulse width in prescaled periods |
| cfg_hidrive | input | 1 | High-drive: pulse width forced to one prescaled period |
| cfg_dead | input | 3 | Dead phases after each frame pair |
| cfg_blink_rate | input | 3 | Blink rate exponent B |
| cfg_blink_sel | input | 2 | Blink scope code |
| com_idx | output | 3 | Active common line |
| sof | output | 1 | Start-of-frame tick |
| drive_en | output | 1 | Drive-pulse window |
| dead_phase | output | 1 | Current phase is dead time |
| blink_seg0_off | output | 8 | COM lines forced off on segment 0 |
| blink_rest_off | output | 8 | COM lines forced off on all other segments |

## Verification
The bench builds the block with its default field widths. It keeps the prescaler exponent at 4 or below, so that a phase lasts at most a few hundred clocks. Within that range it sweeps every duty code, both ends of the divider, every dead-time and pulse width, both high-drive settings, every blink scope and the first four blink rates. Each output is compared cycle by cycle against a closed-form model of phase, frame and blink counts. The windows are long enough to include several frame pairs with their dead phases, as well as at least one blink toggle.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;
    localparam int unsigned COM_MAX = 8;
    localparam int unsigned COM_W   = $clog2(COM_MAX);
    localparam int unsigned CNT_W   = COM_W + 1;

    // Number of common lines for a duty code; unused codes fall back to static.
    function automatic logic [CNT_W-1:0] duty_to_coms(input logic [2:0] duty);
        case (duty)
            3'b001:  return CNT_W'(2);
            3'b010:  return CNT_W'(3);
            3'b011:  return CNT_W'(4);
            3'b100:  return CNT_W'(8);
            default: return CNT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/lcd_ft_clkdiv.sv
// Prescaler (2^ps) followed by the phase divider (16+div style: 2^DIV_W + div).
module lcd_ft_clkdiv #(
    parameter int unsigned PS_W  = 4,
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PS_W-1:0]  ps,
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W:0]   pos,
    output logic             first,
    output logic             phase_end
);
    localparam int unsigned PRE_W = (1 << PS_W) - 1;
    localparam int unsigned POS_W = DIV_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [POS_W-1:0] pos;
    } div_st_t;

    div_st_t          s_d, s_q;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] pre_lim;
    logic [POS_W-1:0] pos_lim;
    logic             ps_last, pos_last;

    always_comb begin
        one_sh   = {{PRE_W{1'b0}}, 1'b1} << ps;
        pre_lim  = PRE_W'(one_sh - 1'b1);
        pos_lim  = POS_W'((1 << DIV_W) - 1) + POS_W'(div);
        ps_last  = (s_q.pre == pre_lim);
        pos_last = (s_q.pos == pos_lim);
        s_d      = s_q;
        if (!run) begin
            s_d = '0;
        end else if (ps_last) begin
            s_d.pre = '0;
            s_d.pos = pos_last ? '0 : s_q.pos + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos       = s_q.pos;
    assign first     = (s_q.pre == '0) && (s_q.pos == '0);
    assign phase_end = run && ps_last && pos_last;
endmodule

// File: rtl/lcd_ft_seq.sv
// COM phase stepping, frame pairing and dead-phase insertion.
module lcd_ft_seq
    import lcd_ft_pkg::*;
#(
    parameter int unsigned DEAD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              phase_end,
    input  logic [CNT_W-1:0]  coms,
    input  logic [DEAD_W-1:0] dead,
    output logic [COM_W-1:0]  com,
    output logic              in_dead,
    output logic              frame_done
);
    typedef struct packed {
        logic [COM_W-1:0]  com;
        logic [DEAD_W-1:0] dcnt;
        logic              in_dead;
        logic              pair;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    last_com;

    always_comb begin
        last_com   = ({1'b0, s_q.com} == (coms - 1'b1));
        frame_done = phase_end && !s_q.in_dead && last_com;
        s_d        = s_q;
        if (!run) begin
            s_d = '0;
        end else if (phase_end) begin
            if (s_q.in_dead) begin
                if (s_q.dcnt == (dead - 1'b1)) begin
                    s_d.in_dead = 1'b0;
                    s_d.dcnt    = '0;
                end else begin
                    s_d.dcnt = s_q.dcnt + 1'b1;
                end
            end else if (last_com) begin
                s_d.com  = '0;
                s_d.pair = ~s_q.pair;
                if (s_q.pair && (dead != '0)) s_d.in_dead = 1'b1;
            end else begin
                s_d.com = s_q.com + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign com     = s_q.com;
    assign in_dead = s_q.in_dead;
endmodule

// File: rtl/lcd_ft_blink.sv
// Frame-count blink divider and blink-scope masks.
module lcd_ft_blink
    import lcd_ft_pkg::*;
#(
    parameter int unsigned BLF_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               frame_done,
    input  logic [BLF_W-1:0]   rate,
    input  logic [1:0]         sel,
    input  logic [CNT_W-1:0]   coms,
    output logic [COM_MAX-1:0] seg0_off,
    output logic [COM_MAX-1:0] rest_off
);
    localparam int unsigned BC_W = 3 + (1 << BLF_W) - 1;

    typedef struct packed {
        logic [BC_W-1:0] cnt;
        logic            off;
    } blk_st_t;

    blk_st_t            s_d, s_q;
    logic [BC_W:0]      lim_sh;
    logic [BC_W-1:0]    cnt_lim;
    logic [COM_MAX:0]   act_sh;
    logic [COM_MAX-1:0] act;

    always_comb begin
        lim_sh  = {{BC_W{1'b0}}, 1'b1} << ((BLF_W+1)'(rate) + (BLF_W+1)'(3));
        cnt_lim = BC_W'(lim_sh - 1'b1);
        s_d     = s_q;
        if (!run) begin
            s_d = '0;
        end else if (frame_done) begin
            if (s_q.cnt == cnt_lim) begin
                s_d.cnt = '0;
                s_d.off = ~s_q.off;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        act_sh   = {{COM_MAX{1'b0}}, 1'b1} << coms;
        act      = COM_MAX'(act_sh - 1'b1);
        seg0_off = '0;
        rest_off = '0;
        if (s_q.off) begin
            case (sel)
                2'b01:   seg0_off = COM_MAX'(1);
                2'b10:   seg0_off = act;
                2'b11: begin
                    seg0_off = act;
                    rest_off = act;
                end
                default: seg0_off = '0;
            endcase
        end
    end
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_ft_pkg::*;
#(
    parameter int unsigned PS_W   = 4,
    parameter int unsigned DIV_W  = 4,
    parameter int unsigned PON_W  = 3,
    parameter int unsigned DEAD_W = 3,
    parameter int unsigned BLF_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [PS_W-1:0]    cfg_prescale,
    input  logic [DIV_W-1:0]   cfg_divide,
    input  logic [2:0]         cfg_duty,
    input  logic [PON_W-1:0]   cfg_pulse,
    input  logic               cfg_hidrive,
    input  logic [DEAD_W-1:0]  cfg_dead,
    input  logic [BLF_W-1:0]   cfg_blink_rate,
    input  logic [1:0]         cfg_blink_sel,
    output logic [COM_W-1:0]   com_idx,
    output logic               sof,
    output logic               drive_en,
    output logic               dead_phase,
    output logic [COM_MAX-1:0] blink_seg0_off,
    output logic [COM_MAX-1:0] blink_rest_off
);
    localparam int unsigned POS_W = DIV_W + 1;
    localparam int unsigned CMP_W = (POS_W > PON_W) ? POS_W : PON_W;

    logic [CNT_W-1:0]   coms;
    logic [POS_W-1:0]   pos;
    logic               first, phase_end, frame_done, in_dead;
    logic [COM_W-1:0]   com;
    logic [PON_W-1:0]   pon_eff;
    logic [COM_MAX-1:0] m0, m1;

    assign coms = duty_to_coms(cfg_duty);

    lcd_ft_clkdiv #(.PS_W(PS_W), .DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(enable), .ps(cfg_prescale), .div(cfg_divide),
        .pos(pos), .first(first), .phase_end(phase_end)
    );

    lcd_ft_seq #(.DEAD_W(DEAD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(enable), .phase_end(phase_end), .coms(coms),
        .dead(cfg_dead), .com(com), .in_dead(in_dead), .frame_done(frame_done)
    );

    lcd_ft_blink #(.BLF_W(BLF_W)) u_blk (
        .clk(clk), .rst_n(rst_n), .run(enable), .frame_done(frame_done),
        .rate(cfg_blink_rate), .sel(cfg_blink_sel), .coms(coms),
        .seg0_off(m0), .rest_off(m1)
    );

    always_comb begin
        pon_eff        = cfg_hidrive ? PON_W'(1) : cfg_pulse;
        com_idx        = enable ? com : '0;
        dead_phase     = enable && in_dead;
        sof            = enable && first && !in_dead && (com == '0);
        drive_en       = enable && !in_dead && (CMP_W'(pos) < CMP_W'(pon_eff));
        blink_seg0_off = enable ? m0 : '0;
        blink_rest_off = enable ? m1 : '0;
    end
endmodule

// File: rtl/lcd_ft_checker.sv
module lcd_ft_checker
    import lcd_ft_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [2:0]         cfg_duty,
    input logic [COM_W-1:0]   com_idx,
    input logic               sof,
    input logic               drive_en,
    input logic               dead_phase,
    input logic [COM_MAX-1:0] blink_seg0_off,
    input logic [COM_MAX-1:0] blink_rest_off
);
    p_sof_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    p_sof_at_com0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (com_idx == '0) && !dead_phase);

    p_dead_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dead_phase |-> (!drive_en && !sof && (com_idx == '0)));

    p_idle_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (com_idx == '0) && !sof && !drive_en && !dead_phase
                    && (blink_seg0_off == '0) && (blink_rest_off == '0));

    p_com_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ({1'b0, com_idx} < duty_to_coms(cfg_duty)));

    p_com_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (com_idx != $past(com_idx)))
        |-> ((com_idx == COM_W'($past(com_idx) + 1'b1)) || (com_idx == '0)));

    p_mask_nested_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_rest_off != '0) |-> (blink_seg0_off == blink_rest_off));
endmodule

bind lcd_frame_timer lcd_ft_checker u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_duty(cfg_duty),
    .com_idx(com_idx), .sof(sof), .drive_en(drive_en), .dead_phase(dead_phase),
    .blink_seg0_off(blink_seg0_off), .blink_rest_off(blink_rest_off)
);

// File: tb/tb_lcd_frame_timer.sv
module tb_lcd_frame_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] cfg_prescale = '0, cfg_divide = '0;
    logic [2:0] cfg_duty = '0, cfg_pulse = '0, cfg_dead = '0, cfg_blink_rate = '0;
    logic       cfg_hidrive = 1'b0;
    logic [1:0] cfg_blink_sel = '0;
    logic [2:0] com_idx;
    logic       sof, drive_en, dead_phase;
    logic [7:0] blink_seg0_off, blink_rest_off;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lcd_frame_timer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_prescale(cfg_prescale), .cfg_divide(cfg_divide), .cfg_duty(cfg_duty),
        .cfg_pulse(cfg_pulse), .cfg_hidrive(cfg_hidrive), .cfg_dead(cfg_dead),
        .cfg_blink_rate(cfg_blink_rate), .cfg_blink_sel(cfg_blink_sel),
        .com_idx(com_idx), .sof(sof), .drive_en(drive_en), .dead_phase(dead_phase),
        .blink_seg0_off(blink_seg0_off), .blink_rest_off(blink_rest_off)
    );

    function automatic int coms_of(input int duty);
        case (duty)
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 8;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Runs one configuration from a cleared state for w cycles, comparing all outputs.
    task automatic run_cfg(input string tag, input int ps, input int dv, input int duty,
                           input int pon, input int hd, input int dead, input int blf,
                           input int sel, input int w);
        int  act_v [6];
        int  exp_v [6];
        bit  bad   [6];
        string names [6];
        names = '{"com_idx", "sof", "drive_en", "dead_phase", "seg0_mask", "rest_mask"};
        for (int i = 0; i < 6; i++) begin bad[i] = 0; act_v[i] = 0; exp_v[i] = 0; end
        cfg_prescale = 4'(ps); cfg_divide = 4'(dv); cfg_duty = 3'(duty);
        cfg_pulse = 3'(pon); cfg_hidrive = hd[0]; cfg_dead = 3'(dead);
        cfg_blink_rate = 3'(blf); cfg_blink_sel = 2'(sel);
        enable = 1'b1;
        for (int t = 0; t < w; t++) begin
            int p, d, n, pl, k, wi, pos, cp, kk, dd, com, fr, off, act, e [6], a [6];
            #1;
            p = 1 << ps; d = 16 + dv; n = coms_of(duty); pl = p * d;
            k = t / pl; wi = t % pl; pos = wi / p;
            cp = 2 * n + dead; kk = k % cp;
            if (kk < 2 * n) begin dd = 0; com = kk % n; end
            else begin dd = 1; com = 0; end
            fr = (k / cp) * 2 + ((kk >= 2 * n) ? 2 : kk / n);
            off = ((fr / (1 << (3 + blf))) % 2);
            act = (1 << n) - 1;
            e[0] = com;
            e[1] = (wi == 0 && dd == 0 && com == 0) ? 1 : 0;
            e[2] = (dd == 0 && pos < (hd != 0 ? 1 : pon)) ? 1 : 0;
            e[3] = dd;
            e[4] = (off == 0) ? 0 : (sel == 1) ? 1 : (sel >= 2) ? act : 0;
            e[5] = (off != 0 && sel == 3) ? act : 0;
            a[0] = int'(com_idx); a[1] = int'(sof); a[2] = int'(drive_en);
            a[3] = int'(dead_phase); a[4] = int'(blink_seg0_off); a[5] = int'(blink_rest_off);
            for (int i = 0; i < 6; i++) begin
                if (!bad[i] && a[i] != e[i]) begin
                    bad[i] = 1; act_v[i] = a[i]; exp_v[i] = e[i];
                end
            end
            @(negedge clk);
        end
        for (int i = 0; i < 6; i++) begin
            string msg;
            msg = $sformatf("%s ps=%0d div=%0d duty=%0d pon=%0d hd=%0d dead=%0d blf=%0d sel=%0d",
                            names[i], ps, dv, duty, pon, hd, dead, blf, sel);
            check(tag, msg, bad[i] ? act_v[i] : 0, bad[i] ? exp_v[i] : 0);
        end
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset holds counters at zero; enabled outputs show phase 0 start
        enable = 1'b1;
        cfg_duty = 3'b011; cfg_blink_sel = 2'b11;
        repeat (3) @(negedge clk);
        #1;
        check("R12", "com_idx in reset", int'(com_idx), 0);
        check("R12", "sof in reset", int'(sof), 1);
        check("R12", "dead_phase in reset", int'(dead_phase), 0);
        check("R12", "masks in reset", int'(blink_seg0_off) + int'(blink_rest_off), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_cfg("R12", 0, 0, 3, 2, 0, 1, 0, 3, 600);

        // R3 and R5: every legal duty code
        for (int du = 0; du <= 4; du++) run_cfg("R3_R5", 0, 0, du, 2, 0, 1, 0, 3, 2800);
        // R4: unused duty codes act as static
        for (int du = 5; du <= 7; du++) run_cfg("R4", 0, 0, du, 2, 0, 1, 0, 3, 800);
        // R1 and R2: prescaler exponents at both divider extremes
        for (int ps = 0; ps <= 4; ps++) begin
            run_cfg("R1_R2", ps, 0, 1, 3, 0, 0, 0, 0, 2500);
            run_cfg("R1_R2", ps, 15, 1, 3, 0, 0, 0, 0, 3000);
        end
        // R8: all dead-time lengths
        for (int dt = 0; dt <= 7; dt++) run_cfg("R8", 0, 0, 3, 1, 0, dt, 0, 2, 1800);
        // R6: all pulse widths, prescaled
        for (int pw = 0; pw <= 7; pw++) run_cfg("R6", 1, 2, 2, pw, 0, 1, 0, 0, 900);
        // R7: high drive overrides the pulse width
        run_cfg("R7", 1, 0, 2, 0, 1, 2, 0, 0, 900);
        run_cfg("R7", 2, 3, 2, 5, 1, 0, 0, 0, 900);
        run_cfg("R7", 0, 0, 0, 7, 1, 0, 0, 0, 300);
        // R10: all blink scopes
        for (int sl = 0; sl <= 3; sl++) run_cfg("R10", 0, 0, 2, 1, 0, 2, 0, sl, 2500);
        run_cfg("R10", 0, 0, 4, 1, 0, 0, 0, 1, 2500);
        // R9: blink rates
        for (int bf = 0; bf <= 3; bf++)
            run_cfg("R9", 0, 0, 0, 1, 0, 0, bf, 3, 2 * (8 << bf) * 16 + 300);
        run_cfg("R9", 0, 1, 1, 1, 0, 3, 1, 3, 3000);

        // R11: disable mid-run clears outputs and restarts cleanly
        cfg_prescale = 4'd1; cfg_divide = 4'd1; cfg_duty = 3'b010; cfg_pulse = 3'd2;
        cfg_dead = 3'd1; cfg_blink_rate = 3'd0; cfg_blink_sel = 2'b11;
        enable = 1'b1;
        repeat (700) @(negedge clk);
        enable = 1'b0;
        #1;
        check("R11", "outputs while disabled",
              int'(com_idx) + int'(sof) + int'(drive_en) + int'(dead_phase)
              + int'(blink_seg0_off) + int'(blink_rest_off), 0);
        @(negedge clk);
        #1;
        check("R11", "outputs one cycle later",
              int'(com_idx) + int'(sof) + int'(drive_en) + int'(dead_phase)
              + int'(blink_seg0_off) + int'(blink_rest_off), 0);
        @(negedge clk);
        run_cfg("R11", 1, 1, 2, 2, 0, 1, 0, 3, 1500);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule